// File: doc/BRIEF.md
# Learned-Address Table Sequential Dump Engine

This engine walks a learned-address table one index per cycle and hands its valid entries to a host, two at a time. A host starts a dump by writing the start bit of the search control register. The engine then scans upward from index 0 and skips entries whose valid bit is clear. Each valid entry goes into the next free result slot. When both slots are full, the engine raises a result-ready flag and stops.

The host polls the control register until the ready flag is set or the busy bit has cleared. It then reads the two slots. Reading the data word of the second slot acknowledges the pair, empties both slots and lets the scan go on. Once every index has been examined, the busy bit drops on its own. A partly filled pair stays readable after that. The acknowledging read on an idle engine empties the slots, so the next pair reads back as both invalid, which marks the end of the dump.

The table itself is held inside the block. It is filled through a simple write port, which lets a testbench load its contents.

Top module: `addr_dump_top`

## Requirements
- R1: After reset, the control register (offset 0x50), the scan position (0x51) and all four slot words (0x60, 0x68, 0x70, 0x78) read as zero.
- R2: A write to offset 0x50 with bit 7 set starts a dump. From then on, bit 7 of the control register reads 1 until the scan completes.
- R3: Only entries whose data word has bit 16 set are delivered. They arrive in ascending index order, with slot 0 filled before slot 1 in each pair.
- R4: When both slots hold an entry, bit 0 of the control register reads 1 and the scan position stays frozen until the pair is acknowledged.
- R5: A read of offset 0x78 while bit 0 is set clears bit 0, empties both slots and resumes the scan at the next index.
- R6: A slot copies its table entry without change. The MAC/VID word (slot 0 at 0x60, slot 1 at 0x70) holds the MAC in bits 47:0 and the VID in bits 59:48. The data word (slot 0 at 0x68, slot 1 at 0x78) holds the port in bits 8:0, age in bit 14, static in bit 15 and valid in bit 16.
- R7: After the last index has been examined, bits 7 and 0 both read 0. A slot that was not filled reads all-zero, so its valid bit is clear. An entry already placed in slot 0 stays readable.
- R8: A read of offset 0x78 while the engine is idle empties both slots.
- R9: Offset 0x51 reports the next index to examine in bits 14:0. It equals the table depth once the scan is complete.
- R10: A start written while a dump is in progress restarts the scan from index 0 with empty slots.
- R11: A write to offset 0x50 with bit 7 clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register offset for reads and writes |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdEn | input | 1 | Register read strobe; a read can have a side effect at the clock edge |
| regRdData | output | 64 | Read data for regAddr, combinational |
| tblWrEn | input | 1 | Table load strobe |
| tblWrIdx | input | ADDR_W | Table index to load |
| tblWrMacVid | input | 64 | MAC/VID word to load |
| tblWrData | input | 32 | Data word to load |

## Verification
Some properties are checked on every cycle:
- the scan position never moves backwards during a dump;
- the position stays frozen while a pair waits;
- busy drops only with the position at the table depth;
- slot 1 is never valid without slot 0;
- a start is always followed by busy;
- an acknowledge always drops the ready flag.

Other behaviour can only be shown by the bench's scenarios. These cover:
- the exact entries and field values delivered in each slot;
- the skipping of invalid entries;
- the handling of a pair that ends exactly at the last index;
- the partial last pair and the empty table;
- the restart in the middle of a dump;
- the no-effect write.

// File: rtl/addr_dump_pkg.sv
package addr_dump_pkg;
  localparam int MACVID_W = 64;
  localparam int DATA_W   = 32;
  localparam int VALID_BIT = 16;

  localparam logic [7:0] OFS_CTRL    = 8'h50;
  localparam logic [7:0] OFS_POS     = 8'h51;
  localparam logic [7:0] OFS_S0_MV   = 8'h60;
  localparam logic [7:0] OFS_S0_DATA = 8'h68;
  localparam logic [7:0] OFS_S1_MV   = 8'h70;
  localparam logic [7:0] OFS_S1_DATA = 8'h78;

  typedef struct packed {
    logic rewind;     // restart scan from index 0
    logic step;       // examine the current index
    logic clearSlots; // empty both result slots
  } dumpStrobes_t;
endpackage

// File: rtl/addr_dump_ctrl.sv
module addr_dump_ctrl
  import addr_dump_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [7:0]   regAddr,
  input  logic         regWrEn,
  input  logic [7:0]   regWrData,
  input  logic         regRdEn,
  input  logic         exhausted,
  input  logic         pairDone,
  output dumpStrobes_t stb,
  output logic         busy,
  output logic         resValid
);
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_HOLD} state_t;
  state_t state, stateNext;

  logic startReq, ackReq;
  assign startReq = regWrEn && (regAddr == OFS_CTRL) && regWrData[7];
  assign ackReq   = regRdEn && (regAddr == OFS_S1_DATA);

  always_comb begin
    stb.rewind     = startReq;
    stb.step       = (state == ST_SCAN) && !startReq && !exhausted;
    stb.clearSlots = startReq || (ackReq && (state != ST_SCAN));
  end

  always_comb begin
    stateNext = state;
    if (startReq) begin
      stateNext = ST_SCAN;
    end else begin
      unique case (state)
        ST_SCAN: begin
          if (exhausted)     stateNext = ST_IDLE;
          else if (pairDone) stateNext = ST_HOLD;
        end
        ST_HOLD: if (ackReq) stateNext = ST_SCAN;
        default: stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy     = (state != ST_IDLE);
  assign resValid = (state == ST_HOLD);

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> busy); // R2

  AST_ACK_RESUMES: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && resValid && !startReq) |=> !resValid); // R5
endmodule

// File: rtl/addr_dump_dp.sv
module addr_dump_dp
  import addr_dump_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  dumpStrobes_t        stb,
  input  logic                busy,
  input  logic                resValid,
  input  logic [7:0]          regAddr,
  output logic [63:0]         regRdData,
  input  logic                tblWrEn,
  input  logic [ADDR_W-1:0]   tblWrIdx,
  input  logic [MACVID_W-1:0] tblWrMacVid,
  input  logic [DATA_W-1:0]   tblWrData,
  output logic                exhausted,
  output logic                pairDone
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int POS_W = ADDR_W + 1;

  logic [MACVID_W-1:0] memMacVid [DEPTH];
  logic [DATA_W-1:0]   memData   [DEPTH];
  logic [POS_W-1:0]    scanPos;
  logic                fillIdx;
  logic [MACVID_W-1:0] slotMacVid [2];
  logic [DATA_W-1:0]   slotData   [2];

  logic [ADDR_W-1:0]   curIdx;
  logic                curValid;
  assign curIdx    = scanPos[ADDR_W-1:0];
  assign exhausted = scanPos[ADDR_W];
  assign curValid  = memData[curIdx][VALID_BIT];
  assign pairDone  = stb.step && curValid && fillIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        memMacVid[i] <= '0;
        memData[i]   <= '0;
      end
    end else if (tblWrEn) begin
      memMacVid[tblWrIdx] <= tblWrMacVid;
      memData[tblWrIdx]   <= tblWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scanPos <= '0;
    end else if (stb.rewind) begin
      scanPos <= '0;
    end else if (stb.step) begin
      scanPos <= scanPos + POS_W'(1);
    end
  end

  for (genvar s = 0; s < 2; s++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN || stb.clearSlots) begin
        slotMacVid[s] <= '0;
        slotData[s]   <= '0;
      end else if (stb.step && curValid && (fillIdx == 1'(s))) begin
        slotMacVid[s] <= memMacVid[curIdx];
        slotData[s]   <= memData[curIdx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clearSlots)  fillIdx <= 1'b0;
    else if (stb.step && curValid) fillIdx <= ~fillIdx;
  end

  always_comb begin
    unique case (regAddr)
      OFS_CTRL:    regRdData = {56'd0, busy, 6'd0, resValid};
      OFS_POS:     regRdData = {48'd0, 1'b0, 15'(scanPos)};
      OFS_S0_MV:   regRdData = slotMacVid[0];
      OFS_S0_DATA: regRdData = {32'd0, slotData[0]};
      OFS_S1_MV:   regRdData = slotMacVid[1];
      OFS_S1_DATA: regRdData = {32'd0, slotData[1]};
      default:     regRdData = '0;
    endcase
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && $past(resValid)) |-> $stable(scanPos)); // R4

  AST_POS_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$past(stb.rewind)) |-> (scanPos >= $past(scanPos))); // R3

  AST_DONE_AT_DEPTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (scanPos == POS_W'(DEPTH))); // R9

  AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    slotData[1][VALID_BIT] |-> slotData[0][VALID_BIT]); // R3
endmodule

// File: rtl/addr_dump_top.sv
module addr_dump_top
  import addr_dump_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  input  logic              regRdEn,
  output logic [63:0]       regRdData,
  input  logic              tblWrEn,
  input  logic [ADDR_W-1:0] tblWrIdx,
  input  logic [63:0]       tblWrMacVid,
  input  logic [31:0]       tblWrData
);
  dumpStrobes_t stb;
  logic busy, resValid, exhausted, pairDone;

  addr_dump_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .exhausted(exhausted),
    .pairDone(pairDone), .stb(stb), .busy(busy), .resValid(resValid)
  );

  addr_dump_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy), .resValid(resValid),
    .regAddr(regAddr), .regRdData(regRdData), .tblWrEn(tblWrEn),
    .tblWrIdx(tblWrIdx), .tblWrMacVid(tblWrMacVid), .tblWrData(tblWrData),
    .exhausted(exhausted), .pairDone(pairDone)
  );
endmodule

// File: tb/addr_dump_top_tb_top.sv
`timescale 1ns/1ps
module addr_dump_top_tb_top;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic        regRdEn = 1'b0;
  logic [63:0] regRdData;
  logic        tblWrEn = 1'b0;
  logic [ADDR_W-1:0] tblWrIdx = '0;
  logic [63:0] tblWrMacVid = '0;
  logic [31:0] tblWrData = '0;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  addr_dump_top #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .tblWrEn(tblWrEn), .tblWrIdx(tblWrIdx), .tblWrMacVid(tblWrMacVid),
    .tblWrData(tblWrData)
  );

  function automatic logic [63:0] mkMv(int i);
    return {4'h0, 12'(i * 37 + 5), 48'h0A1B_0000_0000 | 48'(i * 257 + 3)};
  endfunction

  function automatic logic [31:0] mkData(int i, bit v);
    return {15'd0, v, 1'(i % 2), 1'((i / 2) % 2), 5'd0, 9'(i * 29 + 1)};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk);
    regAddr = a; regWrData = v; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic loadTable(input logic [DEPTH-1:0] validMask);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      tblWrEn = 1'b1; tblWrIdx = ADDR_W'(i);
      tblWrMacVid = mkMv(i); tblWrData = mkData(i, validMask[i]);
    end
    @(negedge clk);
    tblWrEn = 1'b0;
  endtask

  task automatic poll(output logic [63:0] c);
    c = '0;
    for (int k = 0; k < 200; k++) begin
      rd(8'h50, c);
      if (c[0] || !c[7]) break;
    end
  endtask

  task automatic checkSlot(string tag, int s, int idx);
    logic [63:0] d;
    rd(s == 0 ? 8'h60 : 8'h70, d);
    check({tag, " mac/vid"}, d, mkMv(idx));
    if (s == 0) begin
      rd(8'h68, d);
      check({tag, " data"}, d, {32'd0, mkData(idx, 1'b1)});
    end
  endtask

  task automatic testReset();
    logic [63:0] d;
    rd(8'h50, d); check("R1 ctrl", d, 64'h0);
    rd(8'h51, d); check("R1 pos", d, 64'h0);
    rd(8'h60, d); check("R1 s0mv", d, 64'h0);
    rd(8'h68, d); check("R1 s0d", d, 64'h0);
    rd(8'h70, d); check("R1 s1mv", d, 64'h0);
  endtask

  task automatic testSparse();
    logic [63:0] d;
    loadTable(16'h0224);
    wr(8'h50, 8'h80);
    rd(8'h50, d); check("R2 busy", d, 64'h80);
    poll(d); check("R4 ready", d, 64'h81);
    checkSlot("R3 R6 slot0 idx2", 0, 2);
    checkSlot("R3 R6 slot1 idx5", 1, 5);
    rd(8'h51, d); check("R4 R9 pos held", d, 64'd6);
    rd(8'h51, d); check("R4 pos still", d, 64'd6);
    rd(8'h78, d); check("R6 slot1 data", d, {32'd0, mkData(5, 1'b1)});
    rd(8'h50, d); check("R5 ready cleared", d[0], 64'h0);
    poll(d); check("R7 done", d, 64'h0);
    checkSlot("R7 partial slot0 idx9", 0, 9);
    rd(8'h70, d); check("R7 slot1 empty", d, 64'h0);
    rd(8'h51, d); check("R9 pos end", d, 64'(DEPTH));
    rd(8'h78, d); check("R7 slot1 data empty", d, 64'h0);
    rd(8'h68, d); check("R8 flush slot0", d, 64'h0);
  endtask

  task automatic testEmpty();
    logic [63:0] d;
    loadTable('0);
    wr(8'h50, 8'h80);
    poll(d); check("R3 empty done", d, 64'h0);
    rd(8'h68, d); check("R3 empty slot0", d, 64'h0);
    rd(8'h51, d); check("R9 empty pos", d, 64'(DEPTH));
  endtask

  task automatic testTail();
    logic [63:0] d;
    loadTable(16'hC000);
    wr(8'h50, 8'h80);
    poll(d); check("R4 tail ready", d, 64'h81);
    checkSlot("R3 tail slot0", 0, 14);
    checkSlot("R3 tail slot1", 1, 15);
    rd(8'h51, d); check("R9 tail pos", d, 64'(DEPTH));
    rd(8'h78, d);
    poll(d); check("R7 tail done", d, 64'h0);
    rd(8'h68, d); check("R5 R7 tail slot0 empty", d, 64'h0);
    rd(8'h78, d); check("R7 tail slot1 empty", d, 64'h0);
  endtask

  task automatic testIgnoredWrite();
    logic [63:0] d;
    wr(8'h50, 8'h01);
    rd(8'h50, d); check("R11 ctrl unchanged", d, 64'h0);
    rd(8'h51, d); check("R11 pos unchanged", d, 64'(DEPTH));
  endtask

  task automatic testRestart();
    logic [63:0] d;
    loadTable(16'h009A);
    wr(8'h50, 8'h80);
    poll(d); check("R4 restart first", d, 64'h81);
    checkSlot("R3 first slot0", 0, 1);
    wr(8'h50, 8'h80);
    rd(8'h50, d); check("R10 restart ctrl", d, 64'h80);
    poll(d); check("R10 ready again", d, 64'h81);
    checkSlot("R10 slot0 idx1", 0, 1);
    checkSlot("R10 slot1 idx3", 1, 3);
    rd(8'h51, d); check("R10 pos", d, 64'd4);
    rd(8'h78, d);
    poll(d); check("R5 second pair", d, 64'h81);
    checkSlot("R5 slot0 idx4", 0, 4);
    checkSlot("R5 slot1 idx7", 1, 7);
    rd(8'h78, d);
    poll(d); check("R7 restart done", d, 64'h0);
    rd(8'h68, d); check("R7 end pair slot0", d, 64'h0);
    rd(8'h78, d); check("R7 end pair slot1", d, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSparse();
    testEmpty();
    testTail();
    testIgnoredWrite();
    testRestart();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule